// File: doc/BRIEF.md
# Configurable Two-Level AND-OR Array

This block is a small sum-of-products fabric whose wiring is set by configuration, not by synthesis. It holds two connection planes. The first plane says which input literals feed each product term; every input offers a true and a complemented literal. The second plane says which product terms feed each output. The outputs are computed combinationally from the data inputs, and the stored connections decide the logic function.

A build parameter picks one of two variants. In the full-array variant, both planes are loadable and one term can drive any number of outputs. In the fixed-OR variant, each output owns a private group of terms. Only the literal plane is loaded.

Configuration arrives as a serial bit stream. Reset puts the array back in the blank state, in which every connection is present and every output therefore reads 0. The outputs are held at 0 for as long as loading is in progress.

Top module: `cfg_and_or_array`

## Requirements
- R1: Three parameters set the geometry: the input count (default 3), the term count (default 5) and the output count (default 4). In fixed-OR mode the term count is the output count times the per-output group size (default 4), and the term-count parameter is ignored.
- R2: A product term is 1 when every connected literal holds. A connected true literal needs its input at 1, and a connected complemented literal needs its input at 0. A term with no literal connected is constant 1.
- R3: When loading is not in progress, an output is 1 exactly when at least one of its connected terms is 1. An output with no active connected term reads 0.
- R4: In full-array mode, one product term may drive several outputs at the same time.
- R5: While cfg_en is high, one bit is taken from cfg_din on each rising edge of cfg_clk. The literal-plane bits come first:
  - terms are sent in ascending order;
  - within a term, inputs are sent in ascending order;
  - for each input, the true-literal bit comes before the complemented-literal bit.
  In full-array mode the OR-plane bits follow: outputs in ascending order, and within an output, terms in ascending order. A bit of 1 means connected. While cfg_en is low, the stored configuration does not change.
- R6: While cfg_en is high, every output reads 0.
- R7: An active-low asynchronous reset (cfg_rst_n) marks every connection as present. The blank array then drives 0 on every output for every input value.
- R8: In fixed-OR mode, output o is fed only by terms o*K to o*K+K-1, where K is the group size. The serial stream then carries only literal-plane bits.
- R9: A term with both the true and the complemented literal of the same input connected is 0 for every input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Clock for the configuration shift chain |
| cfg_rst_n | input | 1 | Asynchronous active-low reset; restores the blank, fully connected array |
| cfg_en | input | 1 | High while configuration bits are being shifted in; forces the outputs to 0 |
| cfg_din | input | 1 | Serial configuration bit; 1 means connected |
| data_in | input | N_IN | Data inputs; bit i is input i |
| data_out | output | N_OUT | Sum-of-products outputs; bit o is output o |

## Verification
The assertions check four things on every cycle:
- the outputs stay silent during loading;
- an output stays 0 when no term is active;
- a term with a contradictory literal pair is 0, and a term with no literal is 1;
- the chain holds its contents when not loading and takes in cfg_din when loading.

In fixed-OR mode, an assertion also checks that each output follows only its own group. The bench scenarios are needed for the rest: the exact bit order of the serial stream, term sharing across outputs, and the function realised after a complete load. These are shown by programming a decimal-to-Gray converter in both variants and comparing every cycle against a behavioural model.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Number of product terms actually built for the chosen variant.
  function automatic int term_total(int fixed_or, int n_term, int n_out, int per_out);
    return (fixed_or != 0) ? n_out * per_out : n_term;
  endfunction

  // Width of the literal (AND) plane: two literals per input per term.
  function automatic int and_bits(int n_pt, int n_in);
    return n_pt * n_in * 2;
  endfunction

  // Stream position of one literal connection bit (comp: 0 true, 1 complemented).
  function automatic int lit_index(int t, int i, int comp, int n_in);
    return (t * n_in + i) * 2 + comp;
  endfunction

  // Position of one OR-plane bit inside the OR-plane field.
  function automatic int or_index(int o, int t, int n_pt);
    return o * n_pt + t;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_din,
  output logic [LEN-1:0] bits_q
);

  // New bits enter at the top; after LEN shifts the first bit sits at index 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits_q <= '1;
    else if (shift_en) bits_q <= {shift_din, bits_q[LEN-1:1]};
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bits_q)); // R5

  AST_CFG_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (bits_q[LEN-1] == $past(shift_din))); // R5

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN = 3,
  parameter int N_PT = 5
) (
  input  logic [N_IN-1:0]        lit_src,
  input  logic [N_PT*N_IN*2-1:0] conn,
  output logic [N_PT-1:0]        term
);

  localparam int LIT_W = 2 * N_IN;

  logic [LIT_W-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = lit_src[i];
    assign lits[2*i+1] = ~lit_src[i];
  end

  // An unconnected literal is treated as 1, so an empty term is constant 1.
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign term[t] = &(lits | ~conn[t*LIT_W +: LIT_W]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT  = 5,
  parameter int N_OUT = 4
) (
  input  logic [N_PT-1:0]       term,
  input  logic [N_PT*N_OUT-1:0] conn,
  output logic [N_OUT-1:0]      sum
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum[o] = |(term & conn[o*N_PT +: N_PT]);
  end

endmodule

// File: rtl/cfg_and_or_array.sv
module cfg_and_or_array #(
  parameter int N_IN          = 3,
  parameter int N_TERM        = 5,
  parameter int N_OUT         = 4,
  parameter int FIXED_OR      = 0,
  parameter int TERMS_PER_OUT = 4
) (
  input  logic             cfg_clk,
  input  logic             cfg_rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] data_out
);

  localparam int N_PT    = pla_pkg::term_total(FIXED_OR, N_TERM, N_OUT, TERMS_PER_OUT);
  localparam int AND_W   = pla_pkg::and_bits(N_PT, N_IN);
  localparam int OR_W    = N_PT * N_OUT;
  localparam int CHAIN_W = AND_W + ((FIXED_OR != 0) ? 0 : OR_W);

  logic [CHAIN_W-1:0] chain_q;
  logic [AND_W-1:0]   and_conn;
  logic [OR_W-1:0]    or_conn;
  logic [N_PT-1:0]    term_vec;
  logic [N_OUT-1:0]   sum_vec;

  // Observation wires for the assertions.
  logic [N_PT-1:0]    term_conflict;
  logic [N_PT-1:0]    term_empty;

  pla_cfg_chain #(.LEN(CHAIN_W)) u_chain (
    .clk       (cfg_clk),
    .rst_n     (cfg_rst_n),
    .shift_en  (cfg_en),
    .shift_din (cfg_din),
    .bits_q    (chain_q)
  );

  assign and_conn = chain_q[AND_W-1:0];

  if (FIXED_OR != 0) begin : g_fixed
    // Hard-wired OR plane: each output owns one contiguous group of terms.
    for (genvar o = 0; o < N_OUT; o++) begin : g_o
      for (genvar t = 0; t < N_PT; t++) begin : g_t
        assign or_conn[pla_pkg::or_index(o, t, N_PT)] = ((t / TERMS_PER_OUT) == o);
      end
      AST_FIXED_GROUP: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (!cfg_en && !(|term_vec[o*TERMS_PER_OUT +: TERMS_PER_OUT])) |-> !data_out[o]); // R8
    end
  end else begin : g_full
    assign or_conn = chain_q[CHAIN_W-1:AND_W];
  end

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .lit_src (data_in),
    .conn    (and_conn),
    .term    (term_vec)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .term (term_vec),
    .conn (or_conn),
    .sum  (sum_vec)
  );

  assign data_out = cfg_en ? '0 : sum_vec;

  for (genvar t = 0; t < N_PT; t++) begin : g_obs
    logic [N_IN-1:0] tru;
    logic [N_IN-1:0] cmp;
    for (genvar i = 0; i < N_IN; i++) begin : g_i
      assign tru[i] = and_conn[pla_pkg::lit_index(t, i, 0, N_IN)];
      assign cmp[i] = and_conn[pla_pkg::lit_index(t, i, 1, N_IN)];
    end
    assign term_conflict[t] = |(tru & cmp);
    assign term_empty[t]    = ~|(tru | cmp);

    AST_CONFLICT_ZERO: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      term_conflict[t] |-> !term_vec[t]); // R9
    AST_EMPTY_ONE: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      term_empty[t] |-> term_vec[t]); // R2
  end

  AST_LOAD_QUIET: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfg_en |-> (data_out == '0)); // R6

  AST_NO_TERM_NO_OUT: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (!cfg_en && (term_vec == '0)) |-> (data_out == '0)); // R3

endmodule

// File: tb/tb_cfg_and_or_array.sv
module tb_cfg_and_or_array;

  localparam int CLK_PERIOD = 10;
  localparam int NI      = 4;
  localparam int NO      = 4;
  localparam int NT_FULL = 10;
  localparam int PER     = 4;
  localparam int NT_FX   = NO * PER;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_a = 1'b0, din_a = 1'b0;
  logic       en_b = 1'b0, din_b = 1'b0;
  logic [3:0] x = 4'h0;
  logic [3:0] out_a, out_b;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Behavioural model state: index 0 = full-array unit, 1 = fixed-OR unit.
  logic [3:0]  m_tm [2][16];
  logic [3:0]  m_cm [2][16];
  logic [15:0] m_or [2][4];
  // Staged contents for the next load.
  logic [3:0]  s_tm [16];
  logic [3:0]  s_cm [16];
  logic [15:0] s_or [4];

  cfg_and_or_array #(.N_IN(NI), .N_TERM(NT_FULL), .N_OUT(NO), .FIXED_OR(0), .TERMS_PER_OUT(PER)) dut (
    .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_en(en_a), .cfg_din(din_a), .data_in(x), .data_out(out_a));

  cfg_and_or_array #(.N_IN(NI), .N_TERM(NT_FULL), .N_OUT(NO), .FIXED_OR(1), .TERMS_PER_OUT(PER)) dut_fx (
    .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_en(en_b), .cfg_din(din_b), .data_in(x), .data_out(out_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] gray_ref(logic [3:0] v);
    case (v)
      4'd0: return 4'b0000;  4'd1: return 4'b0001;
      4'd2: return 4'b0011;  4'd3: return 4'b0010;
      4'd4: return 4'b0110;  4'd5: return 4'b1110;
      4'd6: return 4'b1010;  4'd7: return 4'b1011;
      4'd8: return 4'b1001;  4'd9: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] model_eval(int d, logic [3:0] v);
    logic [3:0] r = 4'h0;
    for (int t = 0; t < 16; t++) begin
      bit on = ((m_tm[d][t] & ~v) == 4'h0) && ((m_cm[d][t] & v) == 4'h0);
      for (int o = 0; o < 4; o++)
        if (on && m_or[d][o][t]) r[o] = 1'b1;
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int t = 0; t < 16; t++) begin
      m_tm[0][t] = 4'hF; m_cm[0][t] = 4'hF;
      m_tm[1][t] = 4'hF; m_cm[1][t] = 4'hF;
    end
    for (int o = 0; o < 4; o++) begin
      m_or[0][o] = 16'h03FF;
      m_or[1][o] = 16'h000F << (4 * o);
    end
  endtask

  task automatic stage_blank();
    for (int t = 0; t < 16; t++) begin s_tm[t] = 4'hF; s_cm[t] = 4'hF; end
    for (int o = 0; o < 4; o++) s_or[o] = 16'h0000;
  endtask

  task automatic set_term(int t, logic [3:0] tm, logic [3:0] cm);
    s_tm[t] = tm; s_cm[t] = cm;
  endtask

  // Serial load: literal bits term by term, input by input, true then complement;
  // then (full unit only) OR bits output by output, term by term.
  task automatic load(int d);
    bit q[$];
    int npt = (d == 0) ? NT_FULL : NT_FX;
    for (int t = 0; t < npt; t++)
      for (int i = 0; i < NI; i++) begin
        q.push_back(s_tm[t][i]);
        q.push_back(s_cm[t][i]);
      end
    if (d == 0)
      for (int o = 0; o < NO; o++)
        for (int t = 0; t < npt; t++) q.push_back(s_or[o][t]);
    for (int k = 0; k < q.size(); k++) begin
      @(negedge clk);
      if (d == 0) begin en_a = 1'b1; din_a = q[k]; end
      else        begin en_b = 1'b1; din_b = q[k]; end
      if (k == q.size() / 2) begin
        x = 4'hF;
        #2 check("R6 outputs silent mid-load", (d == 0) ? out_a : out_b, 4'h0);
      end
    end
    @(negedge clk);
    if (d == 0) en_a = 1'b0; else en_b = 1'b0;
    for (int t = 0; t < 16; t++) begin
      m_tm[d][t] = (t < npt) ? s_tm[t] : 4'hF;
      m_cm[d][t] = (t < npt) ? s_cm[t] : 4'hF;
    end
    if (d == 0) for (int o = 0; o < 4; o++) m_or[0][o] = s_or[o];
  endtask

  task automatic apply(logic [3:0] v);
    @(negedge clk);
    x = v;
    #2;
  endtask

  // Per-cycle comparison against the behavioural model.
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      check("R3 per-cycle model full", out_a, en_a ? 4'h0 : model_eval(0, x));
      check("R3 per-cycle model fixed", out_b, en_b ? 4'h0 : model_eval(1, x));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: blank array reads 0 everywhere
    for (int v = 0; v < 16; v++) begin
      apply(4'(v));
      check("R7 blank full", out_a, 4'h0);
      check("R7 blank fixed", out_b, 4'h0);
    end

    // Full-array Gray converter (R1, R2, R5): inputs A=bit3 .. D=bit0, W=out3 .. Z=out0
    stage_blank();
    set_term(0, 4'b1000, 4'b0000); // A
    set_term(1, 4'b0110, 4'b0000); // BC
    set_term(2, 4'b0101, 4'b0000); // BD
    set_term(3, 4'b0100, 4'b0010); // BC'
    set_term(4, 4'b0100, 4'b0000); // B
    set_term(5, 4'b0010, 4'b0000); // C
    set_term(6, 4'b0001, 4'b1110); // A'B'C'D
    set_term(7, 4'b0111, 4'b0000); // BCD
    set_term(8, 4'b1000, 4'b0001); // AD'
    set_term(9, 4'b0010, 4'b0101); // B'CD'
    s_or[3] = 16'h0007; s_or[2] = 16'h0008; s_or[1] = 16'h0030; s_or[0] = 16'h03C0;
    load(0);
    for (int v = 0; v < 10; v++) begin
      apply(4'(v));
      check("R5 R1 gray full-array", out_a, gray_ref(4'(v)));
    end

    // R5: configuration held while cfg_en low, even with cfg_din toggling
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      din_a = ~din_a;
      x = 4'd5;
      #2 check("R5 hold while idle", out_a, gray_ref(4'd5));
    end

    // Fixed-OR Gray converter (R8): groups Z=0..3, Y=4..7, X=8..11, W=12..15
    stage_blank();
    set_term(0, 4'b0001, 4'b1110);
    set_term(1, 4'b0111, 4'b0000);
    set_term(2, 4'b1000, 4'b0001);
    set_term(3, 4'b0010, 4'b0101);
    set_term(4, 4'b0100, 4'b0000);
    set_term(5, 4'b0010, 4'b0000);
    set_term(8, 4'b0100, 4'b0010);
    set_term(12, 4'b1000, 4'b0000);
    set_term(13, 4'b0110, 4'b0000);
    set_term(14, 4'b0101, 4'b0000);
    load(1);
    for (int v = 0; v < 10; v++) begin
      apply(4'(v));
      check("R8 gray fixed-OR", out_b, gray_ref(4'(v)));
    end

    // R4 sharing, R2 empty term, R9 conflicting term
    stage_blank();
    set_term(0, 4'b1000, 4'b0000);   // A feeds all outputs
    set_term(1, 4'b0000, 4'b0000);   // empty term -> constant 1 on out0
    s_or[3] = 16'h0001; s_or[2] = 16'h0001;
    s_or[1] = 16'h0005;              // term2 is blank (conflicting) -> contributes 0
    s_or[0] = 16'h0003;
    load(0);
    for (int v = 0; v < 16; v++) begin
      apply(4'(v));
      check("R4 R2 R9 shared term", out_a, {v[3], v[3], v[3], 1'b1});
    end

    // R7: reset restores the blank array
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #2 check("R7 reset full", out_a, 4'h0);
    check("R7 reset fixed", out_b, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 16; v += 5) begin
      apply(4'(v));
      check("R7 after reset full", out_a, 4'h0);
      check("R7 after reset fixed", out_b, 4'h0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule